// File: doc/BRIEF.md
# Clear-on-read endpoint interrupt flag bank

This block keeps the interrupt-pending flags of a small device-side endpoint controller. Single-cycle event pulses from the transfer logic set individual flags. There is one flag per endpoint and direction. Software sees the flags through two byte-wide, read-only registers on a simple strobe-and-address register bus. Reading a flag register returns its contents and clears every flag in it. No write is needed to acknowledge.

Each flag register has a companion enable register, and one global enable bit sits in a register of its own. The single interrupt output is a registered level. It is high whenever the global enable is set and at least one flag is pending with its enable bit set. An event that coincides with a read of its own register is never lost. The read returns the older contents, and the new event is left pending for the next read.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset every flag, every enable bit and the global enable are 0, and `irqOut` is 0.
- R2: A one-cycle pulse on `inEvt[0]` or `inEvt[1]` sets bit 0 or bit 1 of the IN flag register at address 0x02. A pulse on `outEvt[1]` sets bit 1 of the OUT flag register at address 0x04. A set flag stays set until that register is read.
- R3: A read (`busRd`=1) of 0x02 or 0x04 returns the held flags in the same cycle and clears all flags of that register at the next clock edge. The other flag register is not affected.
- R4: If an event for a flag arrives in the same cycle as a read of its register, the read returns the value held before that cycle. The flag is 1 after the edge.
- R5: Writes (`busWr`=1) to 0x02 or 0x04 change no flag.
- R6: Unused flag bits always read 0. These are IN bits 7..2 and OUT bits 7..2 and 0. Event pulses on the matching `inEvt`/`outEvt` lines are ignored.
- R7: The IN enable register at 0x07 (bits 1..0) and the OUT enable register at 0x09 (bit 1 only) are read/write. The global enable is bit 0 at 0x0B. Unimplemented bits read 0.
- R8: `irqOut` is 1 exactly when the global enable is 1 and some flag is 1 together with its enable bit. It follows any set event, enable write or clear with one clock edge of latency.
- R9: A read that clears the last enabled pending flag makes `irqOut` 0 at the same clock edge that applies the clear.
- R10: `busRdata` is 0 when `busRd` is 0 or the address maps to no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busRd | input | 1 | Single-cycle read strobe |
| busWr | input | 1 | Single-cycle write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational while `busRd` is 1 |
| inEvt | input | 8 | IN-side flag set pulses, one per bit |
| outEvt | input | 8 | OUT-side flag set pulses, one per bit |
| irqOut | output | 1 | Aggregated registered interrupt level |

## Verification
The bench builds the block with its default parameters: 8-bit address and data, the register map above, an IN mask of 0x03 and an OUT mask of 0x02. With these parameters each flag register holds at most two live bits. That makes it cheap to drive all 256 event patterns on each side, and to sweep every combination of enable bits, global enable and pending flags against an arithmetic model of `irqOut`. The small address space also allows a full sweep of the low addresses, covering both decoded and unmapped reads. Every read, write and event collision is timed against the clock edge.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_INFLAG  = 3'd1,
    SEL_OUTFLAG = 3'd2,
    SEL_INEN    = 3'd3,
    SEL_OUTEN   = 3'd4,
    SEL_GLOBAL  = 3'd5
  } readSel_e;

  typedef struct packed {
    logic     clrIn;
    logic     clrOut;
    logic     wrInEn;
    logic     wrOutEn;
    logic     wrGlobal;
    readSel_e rdSel;
  } bankStrobes_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int IN_FLAG_ADDR  = 8'h02,
  parameter int OUT_FLAG_ADDR = 8'h04,
  parameter int IN_EN_ADDR    = 8'h07,
  parameter int OUT_EN_ADDR   = 8'h09,
  parameter int GLOBAL_ADDR   = 8'h0B
) (
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output bankStrobes_t      strb
);

  localparam logic [ADDR_W-1:0] InFlagA  = ADDR_W'(IN_FLAG_ADDR);
  localparam logic [ADDR_W-1:0] OutFlagA = ADDR_W'(OUT_FLAG_ADDR);
  localparam logic [ADDR_W-1:0] InEnA    = ADDR_W'(IN_EN_ADDR);
  localparam logic [ADDR_W-1:0] OutEnA   = ADDR_W'(OUT_EN_ADDR);
  localparam logic [ADDR_W-1:0] GlobalA  = ADDR_W'(GLOBAL_ADDR);

  logic hitInFlag, hitOutFlag, hitInEn, hitOutEn, hitGlobal;

  always_comb begin
    hitInFlag  = (busAddr == InFlagA);
    hitOutFlag = (busAddr == OutFlagA);
    hitInEn    = (busAddr == InEnA);
    hitOutEn   = (busAddr == OutEnA);
    hitGlobal  = (busAddr == GlobalA);
  end

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_NONE;
    // Flag registers clear only on reads; writes to them decode to nothing.
    strb.clrIn    = busRd & hitInFlag;
    strb.clrOut   = busRd & hitOutFlag;
    strb.wrInEn   = busWr & hitInEn;
    strb.wrOutEn  = busWr & hitOutEn;
    strb.wrGlobal = busWr & hitGlobal;
    if (busRd) begin
      if (hitInFlag)       strb.rdSel = SEL_INFLAG;
      else if (hitOutFlag) strb.rdSel = SEL_OUTFLAG;
      else if (hitInEn)    strb.rdSel = SEL_INEN;
      else if (hitOutEn)   strb.rdSel = SEL_OUTEN;
      else if (hitGlobal)  strb.rdSel = SEL_GLOBAL;
    end
  end

endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [DATA_W-1:0] IN_MASK  = 8'h03,
  parameter logic [DATA_W-1:0] OUT_MASK = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] inEvt,
  input  logic [DATA_W-1:0] outEvt,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut
);

  logic [DATA_W-1:0] inFlags, outFlags, inEn, outEn;
  logic [DATA_W-1:0] inFlagsNxt, outFlagsNxt, inEnNxt, outEnNxt;
  logic [DATA_W-1:0] inEvtLive, outEvtLive;
  logic              globalEn, globalEnNxt, irqNxt;

  always_comb begin
    inEvtLive   = inEvt & IN_MASK;
    outEvtLive  = outEvt & OUT_MASK;
    // Clear first, then OR in the new events, so a colliding event survives.
    inFlagsNxt  = ((strb.clrIn  ? '0 : inFlags)  | inEvtLive)  & IN_MASK;
    outFlagsNxt = ((strb.clrOut ? '0 : outFlags) | outEvtLive) & OUT_MASK;
    inEnNxt     = strb.wrInEn  ? (wdata & IN_MASK)  : inEn;
    outEnNxt    = strb.wrOutEn ? (wdata & OUT_MASK) : outEn;
    globalEnNxt = strb.wrGlobal ? wdata[0] : globalEn;
    irqNxt      = globalEnNxt & (|(inFlagsNxt & inEnNxt) | |(outFlagsNxt & outEnNxt));
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (IN_MASK[b]) begin : g_inLive
      always_ff @(posedge clk) begin
        if (!rstN) begin
          inFlags[b] <= 1'b0;
          inEn[b]    <= 1'b0;
        end else begin
          inFlags[b] <= inFlagsNxt[b];
          inEn[b]    <= inEnNxt[b];
        end
      end
    end else begin : g_inTied
      always_ff @(posedge clk) begin
        inFlags[b] <= 1'b0;
        inEn[b]    <= 1'b0;
      end
    end
    if (OUT_MASK[b]) begin : g_outLive
      always_ff @(posedge clk) begin
        if (!rstN) begin
          outFlags[b] <= 1'b0;
          outEn[b]    <= 1'b0;
        end else begin
          outFlags[b] <= outFlagsNxt[b];
          outEn[b]    <= outEnNxt[b];
        end
      end
    end else begin : g_outTied
      always_ff @(posedge clk) begin
        outFlags[b] <= 1'b0;
        outEn[b]    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      globalEn <= globalEnNxt;
      irqOut   <= irqNxt;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_INFLAG:  rdata = inFlags;
      SEL_OUTFLAG: rdata = outFlags;
      SEL_INEN:    rdata = inEn;
      SEL_OUTEN:   rdata = outEn;
      SEL_GLOBAL:  rdata = {{(DATA_W-1){1'b0}}, globalEn};
      default:     rdata = '0;
    endcase
  end

  AST_CLEAR_ON_READ_IN: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrIn |=> ((inFlags & ~$past(inEvtLive)) == '0)); // R3
  AST_CLEAR_ON_READ_OUT: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrOut |=> ((outFlags & ~$past(outEvtLive)) == '0)); // R3
  AST_EVENT_NOT_LOST: assert property (@(posedge clk) disable iff (!rstN)
    (|inEvtLive) |=> ((inFlags & $past(inEvtLive)) == $past(inEvtLive))); // R4
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((inFlags & ~IN_MASK) == '0) && ((outFlags & ~OUT_MASK) == '0)); // R6
  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> globalEn); // R8
  AST_FLAG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrIn && inEvtLive == '0) |=> $stable(inFlags)); // R5

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int IN_FLAG_ADDR  = 8'h02,
  parameter int OUT_FLAG_ADDR = 8'h04,
  parameter int IN_EN_ADDR    = 8'h07,
  parameter int OUT_EN_ADDR   = 8'h09,
  parameter int GLOBAL_ADDR   = 8'h0B,
  parameter logic [DATA_W-1:0] IN_MASK  = 8'h03,
  parameter logic [DATA_W-1:0] OUT_MASK = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] inEvt,
  input  logic [DATA_W-1:0] outEvt,
  output logic              irqOut
);

  bankStrobes_t strb;

  irq_bank_ctrl #(
    .ADDR_W(ADDR_W), .IN_FLAG_ADDR(IN_FLAG_ADDR), .OUT_FLAG_ADDR(OUT_FLAG_ADDR),
    .IN_EN_ADDR(IN_EN_ADDR), .OUT_EN_ADDR(OUT_EN_ADDR), .GLOBAL_ADDR(GLOBAL_ADDR)
  ) i_ctrl (
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .strb(strb)
  );

  irq_bank_dp #(
    .DATA_W(DATA_W), .IN_MASK(IN_MASK), .OUT_MASK(OUT_MASK)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .inEvt(inEvt), .outEvt(outEvt), .rdata(busRdata), .irqOut(irqOut)
  );

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == '0)); // R10

endmodule

// File: tb/test_irq_flag_bank.sv
module test_irq_flag_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] inEvt = '0;
  logic [7:0] outEvt = '0;
  logic       irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_bank i_irq_flag_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .inEvt(inEvt), .outEvt(outEvt),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic pulseEvt(input logic [7:0] inP, input logic [7:0] outP);
    @(negedge clk); inEvt = inP; outEvt = outP;
    @(negedge clk); inEvt = '0; outEvt = '0;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 check(tag, busRdata, exp);
    @(negedge clk); busRd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq", {7'd0, irqOut}, 8'h00);
    busRead(8'h02, 8'h00, "R1 in flags");
    busRead(8'h04, 8'h00, "R1 out flags");
    busRead(8'h07, 8'h00, "R1 in en");
    busRead(8'h09, 8'h00, "R1 out en");
    busRead(8'h0B, 8'h00, "R1 global");

    // R2 R6: every event pattern on each side
    for (int p = 0; p < 256; p++) begin
      pulseEvt(8'(p), 8'(p));
      busRead(8'h02, 8'(p) & 8'h03, "R2 R6 in pattern");
      busRead(8'h04, 8'(p) & 8'h02, "R2 R6 out pattern");
    end

    // R3: read of one register leaves the other alone
    pulseEvt(8'h03, 8'h02);
    busRead(8'h02, 8'h03, "R3 in read");
    busRead(8'h02, 8'h00, "R3 in cleared");
    busRead(8'h04, 8'h02, "R3 out untouched");
    busRead(8'h04, 8'h00, "R3 out cleared");

    // R4: event during read of its own register
    pulseEvt(8'h02, 8'h00);
    @(negedge clk); busAddr = 8'h02; busRd = 1'b1; inEvt = 8'h01;
    #1 check("R4 read returns old", busRdata, 8'h02);
    @(negedge clk); busRd = 1'b0; inEvt = '0;
    busRead(8'h02, 8'h01, "R4 event kept");
    @(negedge clk); busAddr = 8'h04; busRd = 1'b1; outEvt = 8'h02;
    #1 check("R4 out read old", busRdata, 8'h00);
    @(negedge clk); busRd = 1'b0; outEvt = '0;
    busRead(8'h04, 8'h02, "R4 out event kept");

    // R5: writes to flag registers
    busWrite(8'h02, 8'hFF);
    busWrite(8'h04, 8'hFF);
    busRead(8'h02, 8'h00, "R5 in write set nothing");
    busRead(8'h04, 8'h00, "R5 out write set nothing");
    pulseEvt(8'h01, 8'h02);
    busWrite(8'h02, 8'h00);
    busWrite(8'h04, 8'h00);
    busRead(8'h02, 8'h01, "R5 in write cleared nothing");
    busRead(8'h04, 8'h02, "R5 out write cleared nothing");

    // R7: enable registers and their masks
    busWrite(8'h07, 8'hFF); busRead(8'h07, 8'h03, "R7 in en mask");
    busWrite(8'h09, 8'hFF); busRead(8'h09, 8'h02, "R7 out en mask");
    busWrite(8'h0B, 8'hFF); busRead(8'h0B, 8'h01, "R7 global mask");
    busWrite(8'h07, 8'h00); busWrite(8'h09, 8'h00); busWrite(8'h0B, 8'h00);

    // R8: sweep global, both enable sets and both flag sets
    for (int g = 0; g < 2; g++)
      for (int ie = 0; ie < 4; ie++)
        for (int oe = 0; oe < 2; oe++)
          for (int f = 0; f < 8; f++) begin
            busWrite(8'h0B, 8'(g));
            busWrite(8'h07, 8'(ie));
            busWrite(8'h09, 8'(oe << 1));
            pulseEvt(8'(f & 3), 8'((f >> 2) << 1));
            exp = 8'((g != 0) && (((f & 3 & ie) != 0) || (((f >> 2) & oe) != 0)));
            check("R8 irq level", {7'd0, irqOut}, exp);
            busRead(8'h02, 8'(f & 3), "R8 in flags");
            busRead(8'h04, 8'(((f >> 2) << 1)), "R8 out flags");
          end

    // R8 latency and R9 clear timing
    busWrite(8'h0B, 8'h01); busWrite(8'h07, 8'h03); busWrite(8'h09, 8'h02);
    @(negedge clk); inEvt = 8'h02;
    #1 check("R8 no early irq", {7'd0, irqOut}, 8'h00);
    @(negedge clk); inEvt = '0;
    check("R8 irq one edge later", {7'd0, irqOut}, 8'h01);
    @(negedge clk); busAddr = 8'h02; busRd = 1'b1;
    #1 check("R9 irq held during read", {7'd0, irqOut}, 8'h01);
    @(negedge clk); busRd = 1'b0;
    check("R9 irq drops at clear edge", {7'd0, irqOut}, 8'h00);
    pulseEvt(8'h01, 8'h02);
    busRead(8'h02, 8'h01, "R9 partial read");
    check("R9 irq kept by other reg", {7'd0, irqOut}, 8'h01);
    busRead(8'h04, 8'h02, "R9 last read");
    check("R9 irq dropped", {7'd0, irqOut}, 8'h00);

    // R10: low address sweep with all registers populated
    for (int a = 0; a < 16; a++) begin
      pulseEvt(8'h03, 8'h02);
      case (a)
        2: exp = 8'h03; 4: exp = 8'h02; 7: exp = 8'h03;
        9: exp = 8'h02; 11: exp = 8'h01; default: exp = 8'h00;
      endcase
      busRead(8'(a), exp, "R10 address sweep");
    end
    @(negedge clk); busAddr = 8'h07; busRd = 1'b0;
    #1 check("R10 idle read data", busRdata, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule